// File: doc/BRIEF.md
# ASID-tagged multi-way TLB lookup

This block holds the translation entries of an instruction TLB and a data TLB for a 32-bit address space. Each TLB has four refill ways of 4 KB pages and one extra way whose page size is set by a configuration register. Every entry carries a virtual page number, a physical page number, an 8-bit address-space identifier and a 4-bit attribute. A lookup probes all five ways of the selected TLB at the same time. Each way uses an entry index taken from its own address bits.

A ring register packs four 8-bit identifiers. An entry counts as a hit only if its identifier is nonzero and equals one of the four bytes. The byte position of that match is the privilege ring. The result comes one clock after the lookup strobe. It is either a single hit, with way, entry, ring, physical address and attribute, or a fault cause for a miss or for more than one hit. Entries are loaded through a write port. A write may lock an entry so that later writes leave it unchanged.

Top module: `asid_tlb`

## Requirements
- R1: After reset, res_valid and res_hit are 0, the ring register holds 0x04030201, no entry is locked, and every entry's identifier is 0, so any lookup misses.
- R2: A ring-register write stores bits [31:8] of the written value and forces bits [7:0] to 0x01, so ring 0 is always identifier 1.
- R3: An entry matches only when its identifier equals a byte of the ring register. res_ring is the lowest byte position (0 for bits [7:0] up to 3 for bits [31:24]) holding that identifier. An identifier found in no byte never matches.
- R4: An entry whose identifier is 0 never matches, whatever its page number.
- R5: Refill ways 0 to 3 are indexed by vaddr[14:12] (8 entries each) and compare vaddr[31:12] with the stored page number. On a hit, res_paddr = {ppn, vaddr[11:0]}.
- R6: Way 4 has 4 entries. Its page size is 1 MB << (2*k), where k is bits [17:16] of the last configuration write for that TLB (0 after reset). Its entry index is vaddr[21+2k:20+2k]. Only address bits at or above 20+2k are compared. The physical address takes its high bits from the ppn and its low bits from vaddr.
- R7: res_cause is 0 on a single hit. A miss gives 16 for the instruction TLB (lk_dtlb=0) and 24 for the data TLB. Two or more matching ways give 17 (instruction) or 25 (data), with res_hit low. The two TLBs hold separate entries.
- R8: An entry write with ent_lock=1 marks that entry locked. Any later write to a locked entry is ignored. A write with way above 4, or with an index at or above the way's entry count, is ignored.
- R9: A lookup with lk_valid high shows its result on the outputs one clock later, with res_valid high for exactly that cycle. An entry written in the same cycle as a lookup is seen with its old contents.
- R10: On a single hit, res_way and res_idx name the matching way and entry, and res_attr gives its attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup strobe |
| lk_dtlb | input | 1 | 1 selects the data TLB, 0 the instruction TLB |
| lk_vaddr | input | 32 | Lookup virtual address |
| ent_we | input | 1 | Entry write strobe |
| ent_dtlb | input | 1 | TLB selected for the entry write |
| ent_way | input | 3 | Way written |
| ent_idx | input | 3 | Entry written within the way |
| ent_vpn | input | 20 | Virtual page number, address bits [31:12] |
| ent_ppn | input | 20 | Physical page number, address bits [31:12] |
| ent_asid | input | 8 | Address-space identifier, 0 = invalid |
| ent_attr | input | 4 | Attribute |
| ent_lock | input | 1 | Lock the entry against later writes |
| rasid_we | input | 1 | Ring register write strobe |
| rasid_wdata | input | 32 | Ring register write value |
| cfg_we | input | 1 | Page-size configuration write strobe |
| cfg_dtlb | input | 1 | TLB whose configuration is written |
| cfg_wdata | input | 32 | Configuration value; bits [17:16] are used |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Single hit |
| res_cause | output | 6 | 0, or a miss or multi-hit cause code |
| res_way | output | 3 | Hitting way |
| res_idx | output | 3 | Hitting entry |
| res_ring | output | 2 | Ring of the hitting entry |
| res_paddr | output | 32 | Translated physical address |
| res_attr | output | 4 | Attribute of the hitting entry |

## Verification
The hardest case to reach from the ports is a multi-hit in which only some of the candidate entries are live. Their page numbers collide, but whether each one counts depends on the current ring register and on the way-4 page size. A stale identifier or a page-size change can turn a double hit into a single hit or a miss. The random stimulus draws addresses from a small pool of pages, so different ways often hold the same page. It derives write indices from the same address, and it rewrites the ring register and the configuration from time to time. Directed cases then pin down the exact double hit, the way-4 index shift, the locked entry and the write that collides with a lookup.

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb #(
  parameter int REF_WAYS    = 4,
  parameter int REF_ENTRIES = 8,
  parameter logic [5:0] I_MISS  = 6'd16,
  parameter logic [5:0] I_MULTI = 6'd17,
  parameter logic [5:0] D_MISS  = 6'd24,
  parameter logic [5:0] D_MULTI = 6'd25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic        lk_dtlb,
  input  logic [31:0] lk_vaddr,
  input  logic        ent_we,
  input  logic        ent_dtlb,
  input  logic [2:0]  ent_way,
  input  logic [2:0]  ent_idx,
  input  logic [19:0] ent_vpn,
  input  logic [19:0] ent_ppn,
  input  logic [7:0]  ent_asid,
  input  logic [3:0]  ent_attr,
  input  logic        ent_lock,
  input  logic        rasid_we,
  input  logic [31:0] rasid_wdata,
  input  logic        cfg_we,
  input  logic        cfg_dtlb,
  input  logic [31:0] cfg_wdata,
  output logic        res_valid,
  output logic        res_hit,
  output logic [5:0]  res_cause,
  output logic [2:0]  res_way,
  output logic [2:0]  res_idx,
  output logic [1:0]  res_ring,
  output logic [31:0] res_paddr,
  output logic [3:0]  res_attr
);
  localparam int NW   = REF_WAYS + 1;
  localparam int NE   = (REF_ENTRIES > 4) ? REF_ENTRIES : 4;
  localparam int RIDX = $clog2(REF_ENTRIES);

  logic [19:0] vpn_q  [2][NW][NE];
  logic [19:0] ppn_q  [2][NW][NE];
  logic [7:0]  asid_q [2][NW][NE];
  logic [3:0]  attr_q [2][NW][NE];
  logic        lock_q [2][NW][NE];
  logic [31:0] rasid_q;
  logic [1:0]  psz_q [2];

  wire way_ok = int'(ent_way) < NW;
  wire idx_ok = (int'(ent_way) == REF_WAYS) ? (int'(ent_idx) < 4)
                                            : (int'(ent_idx) < REF_ENTRIES);
  wire wr_go  = ent_we && way_ok && idx_ok && !lock_q[ent_dtlb][ent_way][ent_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasid_q  <= 32'h0403_0201;
      psz_q[0] <= '0;
      psz_q[1] <= '0;
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < NW; w++)
          for (int e = 0; e < NE; e++) begin
            vpn_q[t][w][e]  <= '0;
            ppn_q[t][w][e]  <= '0;
            asid_q[t][w][e] <= '0;
            attr_q[t][w][e] <= '0;
            lock_q[t][w][e] <= 1'b0;
          end
    end else begin
      if (rasid_we) rasid_q <= {rasid_wdata[31:8], 8'h01};
      if (cfg_we) psz_q[cfg_dtlb] <= cfg_wdata[17:16];
      if (wr_go) begin
        vpn_q[ent_dtlb][ent_way][ent_idx]  <= ent_vpn;
        ppn_q[ent_dtlb][ent_way][ent_idx]  <= ent_ppn;
        asid_q[ent_dtlb][ent_way][ent_idx] <= ent_asid;
        attr_q[ent_dtlb][ent_way][ent_idx] <= ent_attr;
        lock_q[ent_dtlb][ent_way][ent_idx] <= ent_lock;
      end
    end
  end

  logic [NW-1:0] hit_w;
  logic [1:0]    ring_w [NW];
  logic [2:0]    idx_w  [NW];
  logic [19:0]   msk_w  [NW];

  for (genvar g = 0; g < NW; g++) begin : g_way
    if (g < REF_WAYS) begin : g_ref
      assign idx_w[g] = 3'(lk_vaddr[12 +: RIDX]);
      assign msk_w[g] = '1;
    end else begin : g_var
      logic [1:0] k;
      assign k        = psz_q[lk_dtlb];
      assign idx_w[g] = 3'(lk_vaddr[20 + 2*k +: 2]);
      assign msk_w[g] = 20'hfff00 << (2*k);
    end
    logic [7:0] a;
    logic [3:0] bm;
    assign a = asid_q[lk_dtlb][g][idx_w[g]];
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign bm[b] = rasid_q[8*b +: 8] == a;
    end
    assign ring_w[g] = bm[0] ? 2'd0 : bm[1] ? 2'd1 : bm[2] ? 2'd2 : 2'd3;
    assign hit_w[g]  = (a != 8'd0) && (|bm) &&
                       (((vpn_q[lk_dtlb][g][idx_w[g]] ^ lk_vaddr[31:12]) & msk_w[g]) == 20'd0);
  end

  logic [2:0] sel;
  always_comb begin
    sel = '0;
    for (int w = NW - 1; w >= 0; w--)
      if (hit_w[w]) sel = 3'(w);
  end

  wire single = $countones(hit_w) == 1;
  wire none   = hit_w == '0;
  wire [19:0] hit_ppn = ppn_q[lk_dtlb][sel][idx_w[sel]];
  wire [19:0] pa_hi   = (hit_ppn & msk_w[sel]) | (lk_vaddr[31:12] & ~msk_w[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cause <= '0;
      res_way   <= '0;
      res_idx   <= '0;
      res_ring  <= '0;
      res_paddr <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && single;
      if (lk_valid) begin
        res_cause <= single ? 6'd0 : none ? (lk_dtlb ? D_MISS : I_MISS)
                                          : (lk_dtlb ? D_MULTI : I_MULTI);
        res_way   <= single ? sel : 3'd0;
        res_idx   <= single ? idx_w[sel] : 3'd0;
        res_ring  <= single ? ring_w[sel] : 2'd0;
        res_paddr <= single ? {pa_hi, lk_vaddr[11:0]} : 32'd0;
        res_attr  <= single ? attr_q[lk_dtlb][sel][idx_w[sel]] : 4'd0;
      end
    end
  end
endmodule

module asid_tlb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic       lk_dtlb,
  input logic       res_valid,
  input logic       res_hit,
  input logic [5:0] res_cause
);
  p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  p_no_stray_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  p_hit_is_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid && res_cause == 6'd0);
  p_fault_code_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_cause == 6'd16 || res_cause == 6'd17 ||
                             res_cause == 6'd24 || res_cause == 6'd25);
  p_data_side_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_dtlb |=> res_hit || res_cause[3]);
  p_inst_side_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_dtlb |=> res_hit || !res_cause[3]);
endmodule

bind asid_tlb asid_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_dtlb(lk_dtlb),
  .res_valid(res_valid), .res_hit(res_hit), .res_cause(res_cause)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_dtlb = 0;
  logic [31:0] lk_vaddr = 0;
  logic ent_we = 0, ent_dtlb = 0, ent_lock = 0;
  logic [2:0] ent_way = 0, ent_idx = 0;
  logic [19:0] ent_vpn = 0, ent_ppn = 0;
  logic [7:0] ent_asid = 0;
  logic [3:0] ent_attr = 0;
  logic rasid_we = 0, cfg_we = 0, cfg_dtlb = 0;
  logic [31:0] rasid_wdata = 0, cfg_wdata = 0;
  logic res_valid, res_hit;
  logic [5:0] res_cause;
  logic [2:0] res_way, res_idx;
  logic [1:0] res_ring;
  logic [31:0] res_paddr;
  logic [3:0] res_attr;

  always #2.5 clk = ~clk;

  asid_tlb i_asid_tlb (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [19:0] m_vpn [2][5][8];
  logic [19:0] m_ppn [2][5][8];
  logic [7:0]  m_asid[2][5][8];
  logic [3:0]  m_attr[2][5][8];
  bit          m_lock[2][5][8];
  logic [31:0] m_rasid;
  logic [1:0]  m_k [2];

  logic e_hit; logic [5:0] e_cause; logic [2:0] e_way, e_idx;
  logic [1:0] e_ring; logic [31:0] e_pa; logic [3:0] e_attr;

  function automatic int way_idx(int w, bit dt, logic [31:0] va);
    if (w < 4) return int'(va[14:12]);
    return int'((va >> (20 + 2*m_k[dt])) & 32'd3);
  endfunction

  function automatic logic [19:0] way_msk(int w, bit dt);
    logic [19:0] m;
    if (w < 4) return 20'hfffff;
    m = 20'hfff00 << (2*m_k[dt]);
    return m;
  endfunction

  task automatic predict(bit dt, logic [31:0] va);
    int nh = 0;
    e_way = 0; e_idx = 0; e_ring = 0; e_pa = 0; e_attr = 0;
    for (int w = 0; w < 5; w++) begin
      int i = way_idx(w, dt, va);
      logic [19:0] m = way_msk(w, dt);
      logic [7:0] a = m_asid[dt][w][i];
      int r = -1;
      for (int b = 3; b >= 0; b--) if (m_rasid[8*b +: 8] == a) r = b;
      if (a != 0 && r >= 0 && ((m_vpn[dt][w][i] ^ va[31:12]) & m) == 0) begin
        nh++;
        if (nh == 1) begin
          e_way = 3'(w); e_idx = 3'(i); e_ring = 2'(r); e_attr = m_attr[dt][w][i];
          e_pa = {(m_ppn[dt][w][i] & m) | (va[31:12] & ~m), va[11:0]};
        end
      end
    end
    e_hit = nh == 1;
    e_cause = nh == 1 ? 6'd0 : nh == 0 ? (dt ? 6'd24 : 6'd16) : (dt ? 6'd25 : 6'd17);
    if (nh != 1) begin e_way = 0; e_idx = 0; e_ring = 0; e_pa = 0; e_attr = 0; end
  endtask

  task automatic model_write();
    int w = int'(ent_way), i = int'(ent_idx);
    if (rasid_we) m_rasid = {rasid_wdata[31:8], 8'h01};
    if (cfg_we) m_k[cfg_dtlb] = cfg_wdata[17:16];
    if (ent_we && w < 5 && i < (w == 4 ? 4 : 8) && !m_lock[ent_dtlb][w][i]) begin
      m_vpn[ent_dtlb][w][i] = ent_vpn; m_ppn[ent_dtlb][w][i] = ent_ppn;
      m_asid[ent_dtlb][w][i] = ent_asid; m_attr[ent_dtlb][w][i] = ent_attr;
      m_lock[ent_dtlb][w][i] = ent_lock;
    end
  endtask

  task automatic tick(string tag);
    bit lv = lk_valid;
    if (lv) predict(lk_dtlb, lk_vaddr);
    @(posedge clk);
    model_write();
    #1;
    if (lv) begin
      vectors++;
      if (res_valid !== 1'b1 || res_hit !== e_hit || res_cause !== e_cause ||
          res_way !== e_way || res_idx !== e_idx || res_ring !== e_ring ||
          res_paddr !== e_pa || res_attr !== e_attr) begin
        miscompares++;
        $display("FAIL %s: got v=%0b h=%0b c=%0d w=%0d i=%0d r=%0d pa=%h at=%h exp v=1 h=%0b c=%0d w=%0d i=%0d r=%0d pa=%h at=%h",
                 tag, res_valid, res_hit, res_cause, res_way, res_idx, res_ring, res_paddr, res_attr,
                 e_hit, e_cause, e_way, e_idx, e_ring, e_pa, e_attr);
      end
    end
    lk_valid = 0; ent_we = 0; rasid_we = 0; cfg_we = 0; ent_lock = 0;
  endtask

  task automatic look(bit dt, logic [31:0] va);
    lk_valid = 1; lk_dtlb = dt; lk_vaddr = va;
  endtask

  task automatic wr(bit dt, int w, int i, logic [19:0] v, logic [19:0] p,
                    logic [7:0] a, logic [3:0] at, bit lk);
    ent_we = 1; ent_dtlb = dt; ent_way = 3'(w); ent_idx = 3'(i);
    ent_vpn = v; ent_ppn = p; ent_asid = a; ent_attr = at; ent_lock = lk;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no end of run, exp end within limit");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  logic [31:0] pool [8];

  initial begin
    void'($urandom(32'd1234));
    m_rasid = 32'h0403_0201; m_k[0] = 0; m_k[1] = 0;
    for (int t = 0; t < 2; t++) for (int w = 0; w < 5; w++) for (int e = 0; e < 8; e++) begin
      m_vpn[t][w][e] = 0; m_ppn[t][w][e] = 0; m_asid[t][w][e] = 0;
      m_attr[t][w][e] = 0; m_lock[t][w][e] = 0;
    end
    #12; rst_n = 1;
    @(posedge clk); #1;
    vectors++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: got v=%0b h=%0b exp v=0 h=0", res_valid, res_hit);
    end
    look(0, 32'h1234_5678); tick("R1 empty itlb miss");
    look(1, 32'h1234_5678); tick("R1 empty dtlb miss R7");
    wr(1, 0, 5, 20'h12345, 20'habcde, 8'h04, 4'h7, 0); tick("R5 write");
    look(1, 32'h1234_5678); tick("R1 reset ring value R3 R5 R10 hit");
    look(0, 32'h1234_5678); tick("R7 separate itlb miss");
    rasid_we = 1; rasid_wdata = 32'h0a0b_0cff; tick("R2 write");
    look(1, 32'h1234_5678); tick("R3 identifier absent miss");
    wr(1, 1, 5, 20'h12345, 20'h00111, 8'h01, 4'h3, 0); tick("R2 write");
    look(1, 32'h1234_5678); tick("R2 ring0 forced to 1");
    wr(1, 1, 5, 20'h12345, 20'h00111, 8'h00, 4'h3, 0); tick("R4 write");
    wr(1, 2, 5, 20'h12345, 20'h00222, 8'h0c, 4'h5, 0); tick("R3 write");
    look(1, 32'h1234_5678); tick("R4 zero identifier ignored R3 ring1");
    wr(1, 3, 5, 20'h12345, 20'h00333, 8'h0b, 4'h1, 0); tick("R7 write");
    look(1, 32'h1234_5678); tick("R7 data multi-hit");
    wr(0, 0, 5, 20'h12345, 20'h00444, 8'h0a, 4'h1, 0); tick("R7 write");
    wr(0, 2, 5, 20'h12345, 20'h00555, 8'h01, 4'h1, 0); tick("R7 write");
    look(0, 32'h1234_5678); tick("R7 instruction multi-hit");
    cfg_we = 1; cfg_dtlb = 1; cfg_wdata = 32'h0002_0000; tick("R6 cfg");
    wr(1, 4, 3, 20'h53000, 20'h7f000, 8'h01, 4'h2, 0); tick("R6 write");
    look(1, 32'h5312_3456); tick("R6 way4 16MB hit");
    cfg_we = 1; cfg_dtlb = 1; cfg_wdata = 32'h0000_0000; tick("R6 cfg");
    look(1, 32'h5312_3456); tick("R6 way4 1MB index shift miss");
    wr(0, 0, 2, 20'h00002, 20'h11111, 8'h01, 4'h6, 1); tick("R8 lock write");
    wr(0, 0, 2, 20'h00002, 20'h22222, 8'h01, 4'h6, 0); tick("R8 blocked write");
    look(0, 32'h0000_2abc); tick("R8 locked entry unchanged");
    wr(0, 5, 2, 20'h00002, 20'h33333, 8'h01, 4'h6, 0); tick("R8 bad way write");
    wr(0, 4, 6, 20'h00002, 20'h33333, 8'h01, 4'h6, 0); tick("R8 bad index write");
    look(0, 32'h0000_2abc); tick("R8 illegal writes ignored");
    look(0, 32'h0000_3000); wr(0, 0, 3, 20'h00003, 20'h44444, 8'h01, 4'h1, 0);
    tick("R9 same-cycle lookup sees old");
    look(0, 32'h0000_3000); tick("R9 next lookup sees new");

    for (int p = 0; p < 8; p++) pool[p] = $urandom & 32'h3333_7000;
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      logic [31:0] va = pool[$urandom % 8] | ($urandom & 32'hfff);
      bit dt = 1'($urandom);
      if (r < 30) begin
        int w = ($urandom % 16 == 0) ? int'(5 + $urandom % 3) : int'($urandom % 5);
        int i = (w < 5) ? way_idx(w, dt, va) : 0;
        logic [7:0] a;
        case ($urandom % 6)
          0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h02; 3: a = 8'h03; 4: a = 8'h04; default: a = 8'h05;
        endcase
        if ($urandom % 10 == 0) i = int'($urandom % 8);
        wr(dt, w, i, va[31:12], 20'($urandom), a, 4'($urandom), $urandom % 25 == 0);
      end
      if (r >= 20) look(1'($urandom), pool[$urandom % 8] | ($urandom & 32'hfff));
      if ($urandom % 40 == 0) begin
        rasid_we = 1;
        rasid_wdata = {8'(1 + $urandom % 5), 8'(1 + $urandom % 5), 8'(1 + $urandom % 5), 8'($urandom)};
      end
      if ($urandom % 50 == 0) begin
        cfg_we = 1; cfg_dtlb = 1'($urandom); cfg_wdata = $urandom;
      end
      if ($urandom % 500 == 0) pool[$urandom % 8] = $urandom & 32'h3333_7000;
      tick("R3 R5 R6 R7 R10 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule